// File: doc/BRIEF.md
# Paged Indirect Register Window

This block gives a management host a narrow view into a wide internal register space. The host sees a handful of 16-bit registers at a single device address. Behind them is a paged space of byte-addressed registers up to 64 bits wide. To reach an internal register, the host does the following:

1. It selects a page.
2. It stages up to four data words.
3. It writes a command word carrying the register offset and a read or write request bit.
4. It polls the command register until the request bit has cleared.

The upstream side is a plain register access port: device address, register number, 16-bit write data, a write qualifier and combinational read data. The serial management framing is handled elsewhere.

The downstream side is an internal register bus. One request carries the page, the offset, the direction and 64 bits of data. The request stays up until an acknowledge arrives, whatever the latency. For a read, the acknowledge also carries the 64-bit result, which lands in the four data words.

While a request is outstanding, the window accepts no host writes. This keeps every request field steady for the whole handshake.

Top module: `pwin_top`

## Requirements
- R1: Host writes to any device address other than 0x1E change nothing, and reads at such an address return 0x0000.
- R2: Register 0x10 stores the page number in bits 15:8 and a page-enable flag in bit 0. Bits 7:1 read as zero. The stored page number drives `busPage`.
- R3: Registers 0x18, 0x19, 0x1A and 0x1B are the four 16-bit data words. Word 0x18 maps to bits 15:0 of the 64-bit data and word 0x1B to bits 63:48.
- R4: Register 0x11 holds the offset in bits 15:8, the write request in bit 0 and the read request in bit 1. If both request bits are written as 1, a write is performed. A command write with both bits 0 only updates the offset, and it starts no request.
- R5: `busReq` rises in the cycle after an accepted command write. `busWrite` shows the direction. All request fields hold steady until the clock edge where `busAck` is sampled high. An acknowledge with no request outstanding has no effect.
- R6: During a write request, `busWdata` carries the four staged data words.
- R7: At the acknowledge of a read request, `busRdata` is loaded into the four data words.
- R8: The request bit that was issued reads back as 1 in register 0x11 for as long as the request is outstanding. It reads back as 0 from the cycle after the acknowledge.
- R9: While a request is outstanding, including its acknowledge cycle, host writes to every window register are ignored.
- R10: After reset, the page register, the command register and all four data words read 0x0000, and no request is outstanding.
- R11: Register numbers at device 0x1E other than 0x10, 0x11 and 0x18 to 0x1B read as 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mgmtValid | input | 1 | Host access strobe |
| mgmtWrite | input | 1 | Host access is a write |
| mgmtDevAddr | input | 5 | Host device address |
| mgmtRegNum | input | 5 | Host register number |
| mgmtWdata | input | 16 | Host write data |
| mgmtRdata | output | 16 | Contents of the addressed register, combinational |
| busReq | output | 1 | Internal request outstanding |
| busWrite | output | 1 | Request direction, 1 means write |
| busPage | output | 8 | Request page |
| busOffset | output | 8 | Request register offset |
| busWdata | output | 64 | Request write data |
| busRdata | input | 64 | Read result, valid with busAck |
| busAck | input | 1 | Request completion |

## Verification
Two events can fall on the same clock edge: the downstream acknowledge that ends a request, and a host write to the window. The bench provokes this by issuing a command with a known acknowledge latency and then timing a fresh command write to arrive exactly at the edge where the acknowledge is sampled. A behavioural model, compared every cycle, expects that write to be dropped. A directed read of the command register afterwards must show the old offset and no pending bit. Stray acknowledges while idle, and writes made during a longer outstanding request, are judged the same way against the model.

// File: rtl/pwin_pkg.sv
package pwin_pkg;
  localparam int WORD_W    = 16;
  localparam int NUM_WORDS = 4;
  localparam int DATA_W    = WORD_W * NUM_WORDS;
  localparam int REG_NUM_W = 5;
  localparam int FIELD_W   = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic                 ldPage;
    logic                 ldCmd;
    logic [NUM_WORDS-1:0] ldWord;
    logic                 capRead;
  } winStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2
  } winState_e;
endpackage

// File: rtl/pwin_ctrl.sv
module pwin_ctrl
  import pwin_pkg::*;
#(
  parameter logic [REG_NUM_W-1:0] PAGE_REG  = 5'h10,
  parameter logic [REG_NUM_W-1:0] CMD_REG   = 5'h11,
  parameter logic [REG_NUM_W-1:0] DATA_BASE = 5'h18
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWr,
  input  logic [REG_NUM_W-1:0] regNum,
  input  logic [1:0]           opBits,
  input  logic                 busAck,
  output winStrobe_t           strobe,
  output logic                 pendW,
  output logic                 pendR
);
  winState_e stateQ, stateD;
  logic busy;
  logic hit;
  logic [NUM_WORDS-1:0] wordHit;

  assign busy = (stateQ != ST_IDLE);
  assign hit  = hostWr && !busy;

  genvar g;
  generate
    for (g = 0; g < NUM_WORDS; g++) begin : g_wordDec
      localparam logic [REG_NUM_W-1:0] WORD_ADDR = REG_NUM_W'(DATA_BASE + g);
      assign wordHit[g] = hit && (regNum == WORD_ADDR);
    end
  endgenerate

  always_comb begin
    strobe         = '0;
    strobe.ldPage  = hit && (regNum == PAGE_REG);
    strobe.ldCmd   = hit && (regNum == CMD_REG);
    strobe.ldWord  = wordHit;
    strobe.capRead = (stateQ == ST_RD) && busAck;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (strobe.ldCmd && opBits[0])      stateD = ST_WR;
        else if (strobe.ldCmd && opBits[1]) stateD = ST_RD;
      end
      ST_WR, ST_RD: begin
        if (busAck) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign pendW = (stateQ == ST_WR);
  assign pendR = (stateQ == ST_RD);
endmodule

// File: rtl/pwin_datapath.sv
module pwin_datapath
  import pwin_pkg::*;
#(
  parameter logic [REG_NUM_W-1:0] PAGE_REG  = 5'h10,
  parameter logic [REG_NUM_W-1:0] CMD_REG   = 5'h11,
  parameter logic [REG_NUM_W-1:0] DATA_BASE = 5'h18
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  winStrobe_t           strobe,
  input  logic [WORD_W-1:0]    wdata,
  input  logic [REG_NUM_W-1:0] regNum,
  input  logic                 devHit,
  input  logic                 pendW,
  input  logic                 pendR,
  input  logic [DATA_W-1:0]    busRdata,
  output logic [WORD_W-1:0]    rdata,
  output logic [FIELD_W-1:0]   pageNum,
  output logic [FIELD_W-1:0]   offset,
  output logic [DATA_W-1:0]    wordsFlat
);
  localparam int PAD_PAGE = WORD_W - FIELD_W - 1;
  localparam int PAD_CMD  = WORD_W - FIELD_W - 2;

  logic                 pageEn;
  logic [WORD_W-1:0]    wordQ [NUM_WORDS];
  logic [NUM_WORDS-1:0] wordSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageNum <= '0;
      pageEn  <= 1'b0;
    end else if (strobe.ldPage) begin
      pageNum <= wdata[WORD_W-1 -: FIELD_W];
      pageEn  <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             offset <= '0;
    else if (strobe.ldCmd) offset <= wdata[WORD_W-1 -: FIELD_W];
  end

  genvar g;
  generate
    for (g = 0; g < NUM_WORDS; g++) begin : g_word
      localparam logic [REG_NUM_W-1:0] WORD_ADDR = REG_NUM_W'(DATA_BASE + g);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 wordQ[g] <= '0;
        else if (strobe.capRead)   wordQ[g] <= busRdata[g*WORD_W +: WORD_W];
        else if (strobe.ldWord[g]) wordQ[g] <= wdata;
      end
      assign wordsFlat[g*WORD_W +: WORD_W] = wordQ[g];
      assign wordSel[g] = (regNum == WORD_ADDR);
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (devHit) begin
      if (regNum == PAGE_REG)     rdata = {pageNum, {PAD_PAGE{1'b0}}, pageEn};
      else if (regNum == CMD_REG) rdata = {offset, {PAD_CMD{1'b0}}, pendR, pendW};
      else begin
        for (int i = 0; i < NUM_WORDS; i++) begin
          if (wordSel[i]) rdata = wordQ[i];
        end
      end
    end
  end
endmodule

// File: rtl/pwin_top.sv
module pwin_top
  import pwin_pkg::*;
#(
  parameter logic [4:0] DEV_ADDR  = 5'h1E,
  parameter logic [4:0] PAGE_REG  = 5'h10,
  parameter logic [4:0] CMD_REG   = 5'h11,
  parameter logic [4:0] DATA_BASE = 5'h18
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mgmtValid,
  input  logic        mgmtWrite,
  input  logic [4:0]  mgmtDevAddr,
  input  logic [4:0]  mgmtRegNum,
  input  logic [15:0] mgmtWdata,
  output logic [15:0] mgmtRdata,
  output logic        busReq,
  output logic        busWrite,
  output logic [7:0]  busPage,
  output logic [7:0]  busOffset,
  output logic [63:0] busWdata,
  input  logic [63:0] busRdata,
  input  logic        busAck
);
  winStrobe_t         strobe;
  logic               devHit;
  logic               hostWr;
  logic               pendW;
  logic               pendR;
  logic [DATA_W-1:0]  wordsFlat;

  assign devHit = (mgmtDevAddr == DEV_ADDR);
  assign hostWr = mgmtValid && mgmtWrite && devHit;

  pwin_ctrl #(
    .PAGE_REG (PAGE_REG),
    .CMD_REG  (CMD_REG),
    .DATA_BASE(DATA_BASE)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .hostWr(hostWr),
    .regNum(mgmtRegNum),
    .opBits(mgmtWdata[1:0]),
    .busAck(busAck),
    .strobe(strobe),
    .pendW (pendW),
    .pendR (pendR)
  );

  pwin_datapath #(
    .PAGE_REG (PAGE_REG),
    .CMD_REG  (CMD_REG),
    .DATA_BASE(DATA_BASE)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wdata    (mgmtWdata),
    .regNum   (mgmtRegNum),
    .devHit   (devHit),
    .pendW    (pendW),
    .pendR    (pendR),
    .busRdata (busRdata),
    .rdata    (mgmtRdata),
    .pageNum  (busPage),
    .offset   (busOffset),
    .wordsFlat(wordsFlat)
  );

  assign busReq   = pendW || pendR;
  assign busWrite = pendW;
  assign busWdata = wordsFlat;
endmodule

// File: rtl/pwin_chk.sv
module pwin_chk #(
  parameter logic [4:0] DEV_ADDR = 5'h1E,
  parameter logic [4:0] CMD_REG  = 5'h11
) (
  input logic        clk,
  input logic        rstN,
  input logic [4:0]  mgmtDevAddr,
  input logic [4:0]  mgmtRegNum,
  input logic [15:0] mgmtRdata,
  input logic        busReq,
  input logic        busWrite,
  input logic [7:0]  busPage,
  input logic [7:0]  busOffset,
  input logic [63:0] busWdata,
  input logic [63:0] busRdata,
  input logic        busAck,
  input logic [63:0] wordsFlat
);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq);

  // R5
  req_fields_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> $stable(busWrite) && $stable(busPage)
                          && $stable(busOffset) && $stable(busWdata));

  // R8
  req_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck |=> !busReq);

  // R7
  read_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck && !busWrite |=> wordsFlat == $past(busRdata));

  // R1
  foreign_dev_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    mgmtDevAddr != DEV_ADDR |-> mgmtRdata == 16'h0000);

  // R8
  cmd_pending_view_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mgmtDevAddr == DEV_ADDR && mgmtRegNum == CMD_REG)
      |-> ((mgmtRdata[1:0] != 2'b00) == busReq));
endmodule

bind pwin_top pwin_chk #(.DEV_ADDR(DEV_ADDR), .CMD_REG(CMD_REG)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .mgmtDevAddr(mgmtDevAddr),
  .mgmtRegNum (mgmtRegNum),
  .mgmtRdata  (mgmtRdata),
  .busReq     (busReq),
  .busWrite   (busWrite),
  .busPage    (busPage),
  .busOffset  (busOffset),
  .busWdata   (busWdata),
  .busRdata   (busRdata),
  .busAck     (busAck),
  .wordsFlat  (wordsFlat)
);

// File: tb/pwin_top_tb_top.sv
module pwin_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mgmtValid = 1'b0;
  logic        mgmtWrite = 1'b0;
  logic [4:0]  mgmtDevAddr = 5'h1E;
  logic [4:0]  mgmtRegNum = 5'h00;
  logic [15:0] mgmtWdata = 16'h0;
  logic [15:0] mgmtRdata;
  logic        busReq;
  logic        busWrite;
  logic [7:0]  busPage;
  logic [7:0]  busOffset;
  logic [63:0] busWdata;
  logic [63:0] busRdata = 64'h0;
  logic        busAck = 1'b0;

  always #2 clk = ~clk;

  pwin_top dut_i (
    .clk(clk), .rstN(rstN), .mgmtValid(mgmtValid), .mgmtWrite(mgmtWrite),
    .mgmtDevAddr(mgmtDevAddr), .mgmtRegNum(mgmtRegNum), .mgmtWdata(mgmtWdata),
    .mgmtRdata(mgmtRdata), .busReq(busReq), .busWrite(busWrite),
    .busPage(busPage), .busOffset(busOffset), .busWdata(busWdata),
    .busRdata(busRdata), .busAck(busAck)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0]  mPage;
  logic        mEn;
  logic [7:0]  mOff;
  logic [15:0] mW [4];
  logic        mPW, mPR;

  task automatic modelReset();
    mPage = 8'h0; mEn = 1'b0; mOff = 8'h0; mPW = 1'b0; mPR = 1'b0;
    for (int i = 0; i < 4; i++) mW[i] = 16'h0;
  endtask

  task automatic modelEdge();
    if (mPW || mPR) begin
      if (busAck) begin
        if (mPR) for (int i = 0; i < 4; i++) mW[i] = busRdata[16*i +: 16];
        mPW = 1'b0; mPR = 1'b0;
      end
    end else if (mgmtValid && mgmtWrite && mgmtDevAddr == 5'h1E) begin
      if (mgmtRegNum == 5'h10) begin
        mPage = mgmtWdata[15:8]; mEn = mgmtWdata[0];
      end else if (mgmtRegNum == 5'h11) begin
        mOff = mgmtWdata[15:8];
        if (mgmtWdata[0]) mPW = 1'b1;
        else if (mgmtWdata[1]) mPR = 1'b1;
      end else if (mgmtRegNum >= 5'h18 && mgmtRegNum <= 5'h1B) begin
        mW[mgmtRegNum - 5'h18] = mgmtWdata;
      end
    end
  endtask

  function automatic logic [15:0] expRd();
    if (mgmtDevAddr != 5'h1E) return 16'h0;
    if (mgmtRegNum == 5'h10) return {mPage, 7'b0, mEn};
    if (mgmtRegNum == 5'h11) return {mOff, 6'b0, mPR, mPW};
    if (mgmtRegNum >= 5'h18 && mgmtRegNum <= 5'h1B) return mW[mgmtRegNum - 5'h18];
    return 16'h0;
  endfunction

  function automatic string rdTag();
    if (mgmtDevAddr != 5'h1E) return "R1";
    if (mgmtRegNum == 5'h10) return "R2";
    if (mgmtRegNum == 5'h11) return "R8";
    if (mgmtRegNum >= 5'h18 && mgmtRegNum <= 5'h1B) return "R3";
    return "R11";
  endfunction

  task automatic compareAll();
    check({rdTag(), " readback"}, 64'(mgmtRdata), 64'(expRd()));
    check("R5 busReq", 64'(busReq), 64'(mPW || mPR));
    check("R5 busWrite", 64'(busWrite), 64'(mPW));
    check("R2 busPage", 64'(busPage), 64'(mPage));
    check("R4 busOffset", 64'(busOffset), 64'(mOff));
    check("R6 busWdata", busWdata, {mW[3], mW[2], mW[1], mW[0]});
  endtask

  task automatic step();
    @(posedge clk);
    if (!rstN) modelReset();
    else modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  // downstream responder, acts 1 ns after each rising edge
  int          ackDelay = 0;
  int          ackCnt = 0;
  logic [63:0] respData = 64'h0;
  bit          strayAck = 1'b0;

  always @(posedge clk) begin
    #1;
    if (busAck) begin
      busAck = 1'b0; ackCnt = 0;
    end else if (strayAck) begin
      busAck = 1'b1; busRdata = 64'hFFFF_FFFF_FFFF_FFFF;
    end else if (busReq) begin
      if (ackCnt >= ackDelay) begin
        busAck = 1'b1; busRdata = respData;
      end else begin
        ackCnt++;
      end
    end
  end

  task automatic hostWriteDev(logic [4:0] dev, logic [4:0] rn, logic [15:0] d);
    mgmtValid = 1'b1; mgmtWrite = 1'b1; mgmtDevAddr = dev; mgmtRegNum = rn; mgmtWdata = d;
    step();
    mgmtValid = 1'b0; mgmtWrite = 1'b0; mgmtDevAddr = 5'h1E;
  endtask

  task automatic hostWrite(logic [4:0] rn, logic [15:0] d);
    hostWriteDev(5'h1E, rn, d);
  endtask

  task automatic hostReadDev(logic [4:0] dev, logic [4:0] rn, output logic [15:0] v);
    mgmtValid = 1'b0; mgmtWrite = 1'b0; mgmtDevAddr = dev; mgmtRegNum = rn;
    step();
    v = mgmtRdata;
    mgmtDevAddr = 5'h1E;
  endtask

  task automatic hostRead(logic [4:0] rn, output logic [15:0] v);
    hostReadDev(5'h1E, rn, v);
  endtask

  task automatic pollDone(string req);
    logic [15:0] v;
    for (int n = 0; n < 50; n++) begin
      hostRead(5'h11, v);
      if (v[1:0] == 2'b00) return;
    end
    check(req, 64'(v[1:0]), 64'h0);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [15:0] v;
    modelReset();
    repeat (3) step();
    rstN = 1'b1;
    step();

    // R10 reset state
    hostRead(5'h10, v); check("R10 page", 64'(v), 64'h0);
    hostRead(5'h11, v); check("R10 cmd", 64'(v), 64'h0);
    for (int i = 0; i < 4; i++) begin
      hostRead(5'(5'h18 + i), v); check("R10 word", 64'(v), 64'h0);
    end
    check("R10 busReq", 64'(busReq), 64'h0);

    // R2 page register
    hostWrite(5'h10, 16'hABCD);
    hostRead(5'h10, v); check("R2 page read", 64'(v), 64'hAB01);
    check("R2 busPage", 64'(busPage), 64'hAB);

    // R3 data word order
    hostWrite(5'h18, 16'h1111);
    hostWrite(5'h19, 16'h2222);
    hostWrite(5'h1A, 16'h3333);
    hostWrite(5'h1B, 16'h4444);
    hostRead(5'h1A, v); check("R3 word2", 64'(v), 64'h3333);
    check("R3 order", busWdata, 64'h4444_3333_2222_1111);

    // write command with latency; R6 R8 R9
    ackDelay = 6;
    hostWrite(5'h11, 16'h3401);
    check("R5 req rise", 64'(busReq), 64'h1);
    check("R6 wdata", busWdata, 64'h4444_3333_2222_1111);
    hostRead(5'h11, v); check("R8 pending", 64'(v), 64'h3401);
    hostWrite(5'h18, 16'hDEAD);
    hostWrite(5'h10, 16'h5501);
    hostWrite(5'h11, 16'h7702);
    hostRead(5'h18, v); check("R9 word kept", 64'(v), 64'h1111);
    hostRead(5'h10, v); check("R9 page kept", 64'(v), 64'hAB01);
    pollDone("R8 clear");
    hostRead(5'h11, v); check("R8 cleared", 64'(v), 64'h3400);

    // R7 read command
    ackDelay = 0;
    respData = 64'h0123_4567_89AB_CDEF;
    hostWrite(5'h11, 16'h5602);
    check("R5 read dir", 64'(busWrite), 64'h0);
    check("R5 read req", 64'(busReq), 64'h1);
    pollDone("R8 read clear");
    hostRead(5'h18, v); check("R7 word0", 64'(v), 64'hCDEF);
    hostRead(5'h1B, v); check("R7 word3", 64'(v), 64'h0123);

    // R4 both bits -> write
    ackDelay = 1;
    hostWrite(5'h11, 16'h7803);
    check("R4 both is write", 64'(busWrite), 64'h1);
    hostRead(5'h11, v); check("R4 both pend", 64'(v), 64'h7801);
    pollDone("R4 clear");

    // R4 no op bits
    hostWrite(5'h11, 16'h9900);
    check("R4 no req", 64'(busReq), 64'h0);
    hostRead(5'h11, v); check("R4 offset only", 64'(v), 64'h9900);

    // R1 foreign device
    hostWriteDev(5'h01, 5'h10, 16'h1234);
    hostRead(5'h10, v); check("R1 page kept", 64'(v), 64'hAB01);
    hostWriteDev(5'h03, 5'h11, 16'h2201);
    check("R1 no req", 64'(busReq), 64'h0);
    hostReadDev(5'h01, 5'h10, v); check("R1 read zero", 64'(v), 64'h0);

    // R11 unmapped registers
    hostWrite(5'h12, 16'hFFFF);
    hostRead(5'h12, v); check("R11 reg12", 64'(v), 64'h0);
    hostRead(5'h1F, v); check("R11 reg1F", 64'(v), 64'h0);

    // R9 host command landing on the acknowledge edge
    ackDelay = 2;
    hostWrite(5'h11, 16'h2101);
    step();
    step();
    hostWrite(5'h11, 16'h4202);
    check("R9 same-edge req", 64'(busReq), 64'h0);
    hostRead(5'h11, v); check("R9 same-edge cmd", 64'(v), 64'h2100);

    // R5 stray acknowledge while idle
    strayAck = 1'b1;
    step();
    strayAck = 1'b0;
    step();
    step();
    hostRead(5'h18, v); check("R5 stray ack", 64'(v), 64'hCDEF);
    check("R5 stray no req", 64'(busReq), 64'h0);

    finishRun();
  end
endmodule